// File: doc/BRIEF.md
# Port Select and Collision Detector

This block is the per-processor front end of one bit plane of a crossbar. A processor shares four pins between two uses. While its phase strobe is high, the pins carry a routing address that names one of sixteen memory lines. Once the strobe drops, the last address seen is held. That line is then requested through a one-hot select and an encoded select toward the crosspoints. Meanwhile, the same pins carry the read/write direction and the write bit.

Write data and the write qualifier are released only while the transfer is live, which means the strobe is low and the clock phase input is high. The data-out enable follows the same rule for reads. Each memory line is the wired OR of everything driven onto it. Because of that, the block reports a clash in only one case: the processor writes a 1 and reads back a 0. A lockout input from the crosspoints is turned into a registered active-low lockout flag.

Top module: `route_port_front`

## Requirements
- R1: When rst_n is sampled low at a clock edge, clsn_n_o and lckd_n_o are 1 afterwards, and the held route code becomes 0.
- R2: While addr_phase_i is 1, sel_line_o is all zeros, sel_code_o is 0, sel_act_o is 0, wr_qual_o is 0, do_oe_o is 0 and wdata_o is 1.
- R3: At every clock edge where addr_phase_i is 1, pins_i is captured as the route code. While addr_phase_i stays 0, pin changes leave sel_code_o unchanged.
- R4: While addr_phase_i is 0, sel_act_o is 1, sel_code_o equals the held route code, and sel_line_o has exactly that bit set.
- R5: wdata_o equals pins_i[0] when addr_phase_i is 0 and phase_i is 1; otherwise wdata_o is 1.
- R6: pins_i[1] is the direction bit, where 1 means read and 0 means write. wr_qual_o is 1 exactly when addr_phase_i is 0, phase_i is 1 and pins_i[1] is 0.
- R7: do_oe_o is 1 exactly when addr_phase_i is 0, phase_i is 1 and pins_i[1] is 1. do_o then equals rdback_i; otherwise do_o is 0.
- R8: After a clock edge that samples addr_phase_i=0, pins_i[1]=0, pins_i[0]=1 and rdback_i=0, clsn_n_o is 0.
- R9: After a clock edge that samples a read (pins_i[1]=1), or a written 0, clsn_n_o is 1.
- R10: After a clock edge that samples addr_phase_i=1, both clsn_n_o and lckd_n_o are 1, whatever rdback_i and line_taken_i are.
- R11: After a clock edge that samples addr_phase_i=0 and line_taken_i=1, lckd_n_o is 0. With line_taken_i=0 it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_phase_i | input | 1 | 1: pins carry the route address; 0: the transfer phase |
| phase_i | input | 1 | Clock phase qualifier for the transfer |
| pins_i | input | 4 | Shared pins: route address, or [1]=read/write and [0]=write bit |
| rdback_i | input | 1 | Value read back from the connected memory line |
| line_taken_i | input | 1 | The requested line is held by another port |
| sel_line_o | output | 16 | One-hot line select |
| sel_code_o | output | 4 | Encoded line select |
| sel_act_o | output | 1 | Select is active |
| wdata_o | output | 1 | Gated write data, idles at 1 |
| wr_qual_o | output | 1 | Memory line write qualifier |
| do_o | output | 1 | Data toward the processor |
| do_oe_o | output | 1 | Output enable for do_o |
| clsn_n_o | output | 1 | Registered collision flag, active low |
| lckd_n_o | output | 1 | Registered lockout flag, active low |

## Verification
The hardest case to reach is an address that must survive pin activity during the transfer phase. The shared pins change to direction and data values, and these look exactly like a different route code. So the stimulus first latches one code. It then drives pins that form another valid code while the strobe is low, and checks that the select does not move. A second route is then latched in the same run. The clash flag is also covered from both sides. Reads with a 0 read back and written 0s must not flag, while a written 1 with a 0 read back must flag even when phase_i is low.

// File: rtl/xbp_pkg.sv
// Shared constants for the port front end.
// Assumes the shared pins use bit 1 for direction and bit 0 for write data.
package xbp_pkg;
    localparam int ROUTE_W = 4;
    localparam int RW_POS  = 1;
    localparam int DI_POS  = 0;
endpackage

// File: rtl/route_capture.sv
// Holds the routing address and decodes it into the line select.
// Assumes addr_phase_i is synchronous to clk. Capture happens on every edge
// in the address phase, so the held code is the last address before the strobe fell.
module route_capture #(
    parameter int ROUTE_W = xbp_pkg::ROUTE_W,
    localparam int LINES  = 1 << ROUTE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               addr_phase_i,
    input  logic [ROUTE_W-1:0] pins_i,
    output logic [LINES-1:0]   sel_line_o,
    output logic [ROUTE_W-1:0] sel_code_o,
    output logic               sel_act_o
);
    logic [ROUTE_W-1:0] route_q;

    // Capture the pins while in the address phase; hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)            route_q <= '0;
        else if (addr_phase_i) route_q <= pins_i;
    end

    // The select is live only in the transfer phase.
    always_comb begin
        sel_act_o  = !addr_phase_i;
        sel_code_o = sel_act_o ? route_q : '0;
    end

    // One decoder leg for each memory line.
    for (genvar gi = 0; gi < LINES; gi++) begin : g_dec
        assign sel_line_o[gi] = sel_act_o && (route_q == ROUTE_W'(gi));
    end

    // R3: the code is held across edges in the transfer phase
    p_hold_route_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(addr_phase_i)) |-> route_q == $past(route_q));
    // R4: at most one line is selected
    p_onehot_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_line_o));
endmodule

// File: rtl/xfer_gate.sv
// Gates the write bit, the write qualifier and the data-out enable with the
// strobe and the clock phase. Purely combinational.
module xfer_gate (
    input  logic addr_phase_i,
    input  logic phase_i,
    input  logic rw_i,
    input  logic di_i,
    input  logic rdback_i,
    output logic wdata_o,
    output logic wr_qual_o,
    output logic do_o,
    output logic do_oe_o
);
    logic live;

    // Derive the direction-dependent controls from the live window.
    always_comb begin
        live      = !addr_phase_i && phase_i;
        wdata_o   = live ? di_i : 1'b1;
        wr_qual_o = live && !rw_i;
        do_oe_o   = live && rw_i;
        do_o      = do_oe_o && rdback_i;
    end

    // R7: reading and writing are never enabled together
    always_comb begin
        p_dir_excl_r7: assert (!(wr_qual_o && do_oe_o));
    end
endmodule

// File: rtl/clash_detect.sv
// Registers the active-low collision and lockout flags.
// Assumes every line is a wired OR, so only a written 1 read back as 0 is visible.
module clash_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic addr_phase_i,
    input  logic rw_i,
    input  logic di_i,
    input  logic rdback_i,
    input  logic line_taken_i,
    output logic clsn_n_o,
    output logic lckd_n_o
);
    logic clash_now, lock_now;

    // Compute the conditions this cycle.
    always_comb begin
        clash_now = !addr_phase_i && !rw_i && di_i && !rdback_i;
        lock_now  = !addr_phase_i && line_taken_i;
    end

    // Register both flags; reset returns them to inactive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clsn_n_o <= 1'b1;
            lckd_n_o <= 1'b1;
        end else begin
            clsn_n_o <= !clash_now;
            lckd_n_o <= !lock_now;
        end
    end

    // R8: a written 1 read back as 0 flags a collision
    p_clash_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!addr_phase_i && !rw_i && di_i && !rdback_i)) |-> !clsn_n_o);
    // R9: reads never flag
    p_read_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rw_i)) |-> clsn_n_o);
    // R10: the address phase releases both flags
    p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(addr_phase_i)) |-> (clsn_n_o && lckd_n_o));
    // R11: a taken line in the transfer phase flags a lockout
    p_lockout_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!addr_phase_i && line_taken_i)) |-> !lckd_n_o);
endmodule

// File: rtl/route_port_front.sv
// Front end of one processor port: route latch, transfer gating and clash flags.
// Assumes pins_i bit 1 is direction (1 = read) and bit 0 is the write bit
// during the transfer phase.
module route_port_front #(
    parameter int ROUTE_W = xbp_pkg::ROUTE_W,
    localparam int LINES  = 1 << ROUTE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               addr_phase_i,
    input  logic               phase_i,
    input  logic [ROUTE_W-1:0] pins_i,
    input  logic               rdback_i,
    input  logic               line_taken_i,
    output logic [LINES-1:0]   sel_line_o,
    output logic [ROUTE_W-1:0] sel_code_o,
    output logic               sel_act_o,
    output logic               wdata_o,
    output logic               wr_qual_o,
    output logic               do_o,
    output logic               do_oe_o,
    output logic               clsn_n_o,
    output logic               lckd_n_o
);
    logic rw, di;

    // Split the shared pins into their transfer-phase roles.
    always_comb begin
        rw = pins_i[xbp_pkg::RW_POS];
        di = pins_i[xbp_pkg::DI_POS];
    end

    route_capture #(.ROUTE_W(ROUTE_W)) u_route (
        .clk(clk), .rst_n(rst_n), .addr_phase_i(addr_phase_i), .pins_i(pins_i),
        .sel_line_o(sel_line_o), .sel_code_o(sel_code_o), .sel_act_o(sel_act_o)
    );

    xfer_gate u_gate (
        .addr_phase_i(addr_phase_i), .phase_i(phase_i), .rw_i(rw), .di_i(di),
        .rdback_i(rdback_i), .wdata_o(wdata_o), .wr_qual_o(wr_qual_o),
        .do_o(do_o), .do_oe_o(do_oe_o)
    );

    clash_detect u_clash (
        .clk(clk), .rst_n(rst_n), .addr_phase_i(addr_phase_i), .rw_i(rw),
        .di_i(di), .rdback_i(rdback_i), .line_taken_i(line_taken_i),
        .clsn_n_o(clsn_n_o), .lckd_n_o(lckd_n_o)
    );

    // R2: an idle port drives no select and no transfer enables
    p_idle_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_phase_i |-> (sel_line_o == '0 && !wr_qual_o && !do_oe_o && wdata_o));
endmodule

// File: tb/sim_route_port_front.sv
module sim_route_port_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_phase_i = 1'b1, phase_i = 1'b0, rdback_i = 1'b0, line_taken_i = 1'b0;
    logic [3:0]  pins_i = 4'h0;
    logic [15:0] sel_line_o;
    logic [3:0]  sel_code_o;
    logic        sel_act_o, wdata_o, wr_qual_o, do_o, do_oe_o, clsn_n_o, lckd_n_o;
    int          n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    route_port_front u0 (
        .clk(clk), .rst_n(rst_n), .addr_phase_i(addr_phase_i), .phase_i(phase_i),
        .pins_i(pins_i), .rdback_i(rdback_i), .line_taken_i(line_taken_i),
        .sel_line_o(sel_line_o), .sel_code_o(sel_code_o), .sel_act_o(sel_act_o),
        .wdata_o(wdata_o), .wr_qual_o(wr_qual_o), .do_o(do_o), .do_oe_o(do_oe_o),
        .clsn_n_o(clsn_n_o), .lckd_n_o(lckd_n_o)
    );

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %0h expected %0h", what, got, exp);
        end
    endtask

    // {ad, phi, pins[3:0], rb, taken, act, code[3:0], wd, wq, oe, clsn_n, lckd_n}
    localparam int NV = 14;
    localparam logic [17:0] TBL [NV] = '{
        {1'b1,1'b0,4'h5,1'b0,1'b0, 1'b0,4'h0,1'b1,1'b0,1'b0,1'b1,1'b1},
        {1'b0,1'b0,4'h0,1'b0,1'b0, 1'b1,4'h5,1'b1,1'b0,1'b0,1'b1,1'b1},
        {1'b0,1'b1,4'h1,1'b1,1'b0, 1'b1,4'h5,1'b1,1'b1,1'b0,1'b1,1'b1},
        {1'b0,1'b1,4'h1,1'b0,1'b0, 1'b1,4'h5,1'b1,1'b1,1'b0,1'b0,1'b1},
        {1'b0,1'b1,4'h0,1'b0,1'b0, 1'b1,4'h5,1'b0,1'b1,1'b0,1'b1,1'b1},
        {1'b0,1'b1,4'h2,1'b0,1'b0, 1'b1,4'h5,1'b0,1'b0,1'b1,1'b1,1'b1},
        {1'b0,1'b1,4'h3,1'b0,1'b0, 1'b1,4'h5,1'b1,1'b0,1'b1,1'b1,1'b1},
        {1'b0,1'b0,4'h1,1'b0,1'b0, 1'b1,4'h5,1'b1,1'b0,1'b0,1'b0,1'b1},
        {1'b0,1'b0,4'hA,1'b0,1'b1, 1'b1,4'h5,1'b1,1'b0,1'b0,1'b1,1'b0},
        {1'b1,1'b1,4'hC,1'b0,1'b1, 1'b0,4'h0,1'b1,1'b0,1'b0,1'b1,1'b1},
        {1'b0,1'b1,4'hF,1'b1,1'b0, 1'b1,4'hC,1'b1,1'b0,1'b1,1'b1,1'b1},
        {1'b1,1'b0,4'h0,1'b0,1'b0, 1'b0,4'h0,1'b1,1'b0,1'b0,1'b1,1'b1},
        {1'b0,1'b1,4'h1,1'b0,1'b1, 1'b1,4'h0,1'b1,1'b1,1'b0,1'b0,1'b0},
        {1'b1,1'b1,4'hF,1'b0,1'b1, 1'b0,4'h0,1'b1,1'b0,1'b0,1'b1,1'b1}
    };

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        @(posedge clk); @(posedge clk); #1;
        chk("R1 clsn_n after reset", 32'(clsn_n_o), 32'd1);
        chk("R1 lckd_n after reset", 32'(lckd_n_o), 32'd1);
        @(negedge clk); rst_n = 1'b1;

        // Vector walk: combinational outputs mid-cycle, registered outputs after the edge.
        for (int i = 0; i < NV; i++) begin
            logic [17:0] v;
            logic [15:0] exp_line;
            logic        exp_do;
            v = TBL[i];
            @(negedge clk);
            addr_phase_i = v[17]; phase_i = v[16]; pins_i = v[15:12];
            rdback_i = v[11]; line_taken_i = v[10];
            #1;
            exp_line = v[9] ? (16'h1 << v[8:5]) : 16'h0;
            exp_do   = v[2] & v[11];
            chk($sformatf("R2/R4 sel_act v%0d", i), 32'(sel_act_o), 32'(v[9]));
            chk($sformatf("R3/R4 sel_code v%0d", i), 32'(sel_code_o), 32'(v[8:5]));
            chk($sformatf("R4 sel_line v%0d", i), 32'(sel_line_o), 32'(exp_line));
            chk($sformatf("R5 wdata v%0d", i), 32'(wdata_o), 32'(v[4]));
            chk($sformatf("R6 wr_qual v%0d", i), 32'(wr_qual_o), 32'(v[3]));
            chk($sformatf("R7 do_oe v%0d", i), 32'(do_oe_o), 32'(v[2]));
            chk($sformatf("R7 do v%0d", i), 32'(do_o), 32'(exp_do));
            @(posedge clk); #1;
            chk($sformatf("R8/R9/R10 clsn_n v%0d", i), 32'(clsn_n_o), 32'(v[1]));
            chk($sformatf("R10/R11 lckd_n v%0d", i), 32'(lckd_n_o), 32'(v[0]));
        end

        // Latch route 9, then raise both flags in the transfer phase.
        @(negedge clk); addr_phase_i = 1'b1; pins_i = 4'h9; line_taken_i = 1'b0;
        @(negedge clk); addr_phase_i = 1'b0; pins_i = 4'h1; rdback_i = 1'b0; line_taken_i = 1'b1;
        #1 chk("R3 route 9 latched", 32'(sel_code_o), 32'h9);
        @(posedge clk); #1;
        chk("R8 clsn_n set", 32'(clsn_n_o), 32'd0);
        chk("R11 lckd_n set", 32'(lckd_n_o), 32'd0);
        // Reset during the transfer phase clears the flags and the route.
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R1 clsn_n cleared", 32'(clsn_n_o), 32'd1);
        chk("R1 lckd_n cleared", 32'(lckd_n_o), 32'd1);
        chk("R1 route cleared", 32'(sel_code_o), 32'h0);
        chk("R1 line 0 selected", 32'(sel_line_o), 32'h1);
        @(negedge clk); rst_n = 1'b1; line_taken_i = 1'b0;

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule